// File: doc/BRIEF.md
# Complementary output short-circuit guard

This block watches three pairs of complementary PWM drive signals, such as the high-side and low-side gate drives of a three-phase inverter. Each pin is brought through a two-stage synchronizer. After that, each pair is compared against an active level chosen per pair by an input. If both members of any pair are active in the same cycle, a sticky short flag is latched.

Software sees the block as one 16-bit control/status word on a simple synchronous register bus with separate read and write strobes and no address. The flag, together with two enable bits, drives two outputs:

- a registered request that makes the pad logic put the monitored pins into high impedance;
- a level interrupt request.

Once the flag is set, it can only be cleared by a write of 0 that follows a read which returned the flag as 1. The high-impedance enable can be set only once after reset.

Top module: `cpair_short_guard`

## Requirements
- R1: After reset, the status word reads 0x0000 and both `hiz_req` and `irq_req` are 0.
- R2: Only bit 15 (short flag), bit 9 (high-impedance enable) and bit 8 (interrupt enable) are implemented. Every other bit reads 0, and writing 1 to any of them changes nothing.
- R3: The flag sets when both pins of any pair are at their active level in the same cycle. Pins pass through two synchronizer stages, so the flag first reads 1 after the third rising edge following the pin change, and not after the second.
- R4: The flag clears only on a write with bit 15 = 0 whose previous bus access was a read that returned bit 15 = 1. A write of 0 without such a read leaves the flag at 1, and writing 1 to bit 15 never sets it.
- R5: `hiz_req` is 1 exactly when the flag and the high-impedance enable are both 1. It updates on the same edge as the flag.
- R6: `irq_req` is a level equal to flag AND interrupt enable. The interrupt enable bit can be read and written at any time.
- R7: Only the first write after reset can change the high-impedance enable. Every later write leaves bit 9 unchanged.
- R8: If a short is present in the same cycle as a valid clearing write, the flag stays 1.
- R9: `act_high[i]` = 1 makes high the active level of pair i, and 0 makes low the active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| drv_hi | input | 3 | High-side drive of each pair |
| drv_lo | input | 3 | Low-side drive of each pair |
| act_high | input | 3 | Per-pair active level: 1 = high, 0 = low |
| reg_rd | input | 1 | Read strobe for the status word |
| reg_wr | input | 1 | Write strobe for the status word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current status word |
| hiz_req | output | 1 | Request to place monitored pins in high impedance |
| irq_req | output | 1 | Level interrupt request |

## Verification
Some rules hold on every cycle, and the assertions check them there:
- reserved bits always read 0;
- both requests always agree with the flag and its enable bits;
- the flag falls only on a write carrying 0 in bit 15;
- the high-impedance enable never moves after the first write.

Other behaviours are only visible through ordered bus and pin scenarios, so the bench's directed tests show them:
- the three-edge synchronizer latency;
- the read-then-write clearing rule;
- set-over-clear priority;
- per-pair polarity.

// File: rtl/csg_pkg.sv
package csg_pkg;
    localparam int unsigned REG_W    = 16;
    localparam int unsigned FLAG_BIT = 15;
    localparam int unsigned HZEN_BIT = 9;
    localparam int unsigned IEN_BIT  = 8;

    typedef struct packed {
        logic flag;
        logic hzen;
        logic hzlock;
        logic ien;
        logic armed;
        logic hiz;
    } ctrl_state_t;
endpackage

// File: rtl/csg_sync.sv
module csg_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/csg_pair_cmp.sv
module csg_pair_cmp (
    input  logic hi,
    input  logic lo,
    input  logic act_high,
    output logic both_active
);
    logic hi_act, lo_act;

    always_comb begin
        hi_act      = act_high ? hi : ~hi;
        lo_act      = act_high ? lo : ~lo;
        both_active = hi_act & lo_act;
    end
endmodule

// File: rtl/csg_ctrl_reg.sv
module csg_ctrl_reg
    import csg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             short_now,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             hiz_req,
    output logic             irq_req
);
    ctrl_state_t st_d, st_q;
    logic        clr_ok;

    always_comb begin
        st_d   = st_q;
        clr_ok = reg_wr && st_q.armed && !reg_wdata[FLAG_BIT];
        if (reg_wr) begin
            st_d.ien   = reg_wdata[IEN_BIT];
            st_d.armed = 1'b0;
            if (!st_q.hzlock) begin
                st_d.hzen   = reg_wdata[HZEN_BIT];
                st_d.hzlock = 1'b1;
            end
        end
        if (reg_rd) begin
            st_d.armed = st_q.flag;
        end
        // a live short outranks a clearing write
        st_d.flag = short_now | (st_q.flag & ~clr_ok);
        st_d.hiz  = st_d.flag & st_d.hzen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata           = '0;
        reg_rdata[FLAG_BIT] = st_q.flag;
        reg_rdata[HZEN_BIT] = st_q.hzen;
        reg_rdata[IEN_BIT]  = st_q.ien;
    end

    assign hiz_req = st_q.hiz;
    assign irq_req = st_q.flag & st_q.ien;
endmodule

// File: rtl/cpair_short_guard.sv
module cpair_short_guard
    import csg_pkg::*;
#(
    parameter int unsigned NUM_PAIRS   = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PAIRS-1:0] drv_hi,
    input  logic [NUM_PAIRS-1:0] drv_lo,
    input  logic [NUM_PAIRS-1:0] act_high,
    input  logic                 reg_rd,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic                 hiz_req,
    output logic                 irq_req
);
    localparam int unsigned SYNC_W = 2 * NUM_PAIRS;

    logic [SYNC_W-1:0]    sync_out;
    logic [NUM_PAIRS-1:0] pair_short;
    logic                 short_now;

    csg_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({drv_lo, drv_hi}),
        .dout (sync_out)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        csg_pair_cmp u_cmp (
            .hi         (sync_out[p]),
            .lo         (sync_out[NUM_PAIRS+p]),
            .act_high   (act_high[p]),
            .both_active(pair_short[p])
        );
    end

    assign short_now = |pair_short;

    csg_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .short_now(short_now),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .hiz_req  (hiz_req),
        .irq_req  (irq_req)
    );
endmodule

// File: rtl/cpair_short_guard_chk.sv
module cpair_short_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [15:0] reg_wdata,
    input logic [15:0] reg_rdata,
    input logic        hiz_req,
    input logic        irq_req
);
    logic seen_wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      seen_wr_q <= 1'b0;
        else if (reg_wr) seen_wr_q <= 1'b1;
    end

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & 16'h7CFF) == 16'h0000);

    assert_flag_fall_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reg_rdata[15]) |-> ($past(reg_wr) && !$past(reg_wdata[15])));

    assert_hiz_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hiz_req == (reg_rdata[15] & reg_rdata[9]));

    assert_irq_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (reg_rdata[15] & reg_rdata[8]));

    assert_hzen_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seen_wr_q |=> $stable(reg_rdata[9]));
endmodule

bind cpair_short_guard cpair_short_guard_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .hiz_req  (hiz_req),
    .irq_req  (irq_req)
);

// File: tb/test_cpair_short_guard.sv
module test_cpair_short_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  drv_hi = '0, drv_lo = '0, act_high = 3'b111;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        hiz_req, irq_req;
    int          total = 0, fails = 0;
    logic [15:0] rv;

    always #2 clk = ~clk;

    cpair_short_guard i_cpair_short_guard (
        .clk(clk), .rst_n(rst_n), .drv_hi(drv_hi), .drv_lo(drv_lo),
        .act_high(act_high), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hiz_req(hiz_req), .irq_req(irq_req)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        cycles(1);
    endtask

    task automatic bus_read(output logic [15:0] d);
        reg_rd = 1'b1;
        #1 d = reg_rdata;
        cycles(1);
        reg_rd = 1'b0;
    endtask

    task automatic bus_write(logic [15:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        cycles(1);
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 rdata", reg_rdata, 16'h0000);
        chk("R1 hiz", {15'd0, hiz_req}, 16'd0);
        chk("R1 irq", {15'd0, irq_req}, 16'd0);
    endtask

    task automatic t_reg_bits();
        bus_write(16'h7EFF);
        chk("R2/R7 first write", reg_rdata, 16'h0200);
        bus_write(16'h0000);
        chk("R7 hzen locked", reg_rdata, 16'h0200);
        bus_write(16'h0100);
        chk("R6 ien writable", reg_rdata, 16'h0300);
    endtask

    task automatic t_no_short();
        drv_hi = 3'b111; drv_lo = 3'b000;
        cycles(4);
        chk("R3 no short hi only", reg_rdata, 16'h0300);
        drv_hi = 3'b010; drv_lo = 3'b101;
        cycles(4);
        chk("R3 no short mixed", reg_rdata, 16'h0300);
        drv_hi = 3'b000; drv_lo = 3'b000;
        cycles(4);
    endtask

    task automatic t_short_set();
        drv_hi = 3'b010; drv_lo = 3'b010;
        cycles(2);
        chk("R3 not before sync", {15'd0, reg_rdata[15]}, 16'd0);
        cycles(1);
        chk("R3 flag set", reg_rdata, 16'h8300);
        chk("R5 hiz on", {15'd0, hiz_req}, 16'd1);
        chk("R6 irq on", {15'd0, irq_req}, 16'd1);
        drv_hi = 3'b000; drv_lo = 3'b000;
        cycles(4);
        chk("R3 flag sticky", {15'd0, reg_rdata[15]}, 16'd1);
    endtask

    task automatic t_clear_rules();
        bus_write(16'h0100);
        chk("R4 write without read keeps flag", {15'd0, reg_rdata[15]}, 16'd1);
        bus_read(rv);
        chk("R4 read value", rv, 16'h8300);
        bus_write(16'h0100);
        chk("R4 cleared", reg_rdata, 16'h0300);
        chk("R5 hiz off", {15'd0, hiz_req}, 16'd0);
        chk("R6 irq off", {15'd0, irq_req}, 16'd0);
        bus_read(rv);
        bus_write(16'h8100);
        chk("R4 write 1 never sets", {15'd0, reg_rdata[15]}, 16'd0);
    endtask

    task automatic t_priority();
        drv_hi = 3'b001; drv_lo = 3'b001;
        cycles(3);
        chk("R3 pair0 short", {15'd0, reg_rdata[15]}, 16'd1);
        bus_read(rv);
        bus_write(16'h0000);
        chk("R8 set beats clear", {15'd0, reg_rdata[15]}, 16'd1);
        chk("R6 irq masked", {15'd0, irq_req}, 16'd0);
        chk("R5 hiz stays", {15'd0, hiz_req}, 16'd1);
        drv_hi = 3'b000; drv_lo = 3'b000;
        cycles(4);
        bus_read(rv);
        bus_write(16'h0000);
        chk("R4 clear after short gone", reg_rdata, 16'h0200);
    endtask

    task automatic t_polarity();
        act_high = 3'b011;
        drv_hi = 3'b000; drv_lo = 3'b000;
        cycles(3);
        chk("R9 active-low pair2 short", {15'd0, reg_rdata[15]}, 16'd1);
        drv_hi = 3'b100; drv_lo = 3'b000;
        cycles(4);
        bus_read(rv);
        bus_write(16'h0000);
        chk("R9 inactive high with low polarity", {15'd0, reg_rdata[15]}, 16'd0);
        act_high = 3'b111;
        drv_hi = 3'b000;
        cycles(4);
    endtask

    task automatic t_hzen_zero_lock();
        do_reset();
        bus_write(16'h0000);
        bus_write(16'h0200);
        chk("R7 later write ignored", reg_rdata, 16'h0000);
        drv_hi = 3'b100; drv_lo = 3'b100;
        cycles(3);
        chk("R5 no hiz without enable", {reg_rdata[15], 14'd0, hiz_req}, 16'h8000);
        drv_hi = 3'b000; drv_lo = 3'b000;
    endtask

    initial begin
        t_reset();
        t_reg_bits();
        t_no_short();
        t_short_set();
        t_clear_rules();
        t_priority();
        t_polarity();
        t_hzen_zero_lock();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule